// File: doc/BRIEF.md
# Multithreaded Block-Move Sequencer

This block carries out multi-word memory-to-memory copy instructions on behalf of several hardware threads at once. Each thread owns a source address, a destination address and a remaining byte count. Once a thread is started, the sequencer moves its operand one 32-bit word per turn through a single shared memory port. A turn is a read of the source word, a write of that word to the destination, and one shared step unit that advances both addresses and shrinks the count. The thread then goes back into the round-robin pool, so the moves of different threads interleave word by word.

When a thread's count reaches zero, the sequencer returns a completion pulse that carries the program-counter increment for the instruction. A thread started as interruptible gives up early when an interrupt is pending after a word has moved. Its advanced addresses and count stay in its registers. A later resume command continues the move from that point.

The FSM states are S_IDLE (choose the next active thread), S_READ (fetch the source word), S_WRITE (store it with byte enables), S_STEP (shared update), S_RETIRE (completion pulse) and S_YIELD (early hand-back). The transitions are:
- S_IDLE to S_READ when the chosen thread has a nonzero count, or to S_RETIRE when its count is zero.
- S_READ to S_WRITE, then S_WRITE to S_STEP.
- S_STEP to S_RETIRE when that word was the last one. Otherwise S_STEP goes to S_YIELD when the thread is interruptible and an interrupt is pending, and to S_IDLE in every other case.
- S_RETIRE and S_YIELD return to S_IDLE.

Top module: `bm_seq`

## Requirements
- R1: After reset, no memory read or write is requested and no completion is signalled until a thread is started.
- R2: Each word turn reads the source word and, in the next cycle, writes the same data to the destination. Both byte addresses then advance by 4, so all of the first len bytes are copied in order.
- R3: Full words are written with mem_be = 4'b1111. A final partial word of r bytes (r = 1..3) uses mem_be = (1<<r)-1, where bit i enables wdata[8i+7:8i] at byte address+i. Destination bytes beyond len keep their old value.
- R4: When the count is used up, done_valid pulses for exactly one cycle with the thread's done_tid, done_pc_inc = 6 and done_yield = 0.
- R5: A zero-length move completes without any memory access.
- R6: For a thread started with start_intr = 1, if irq_pending is high after a word has moved and bytes remain, the thread is handed back: done_valid with done_yield = 1 and done_pc_inc = 0.
- R7: A start with start_load = 0 resumes from the thread's saved addresses and count, so repeated yield/resume completes the same copy as an unbroken move.
- R8: A thread started with start_intr = 0 ignores irq_pending and completes in one go.
- R9: Active threads get word turns in round-robin order, one word per turn, so moves started together finish in order of their word count.
- R10: A start for a thread that is already active is ignored and does not change its move.
- R11: A read and a write are never requested in the same cycle, and every write directly follows a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start or resume command for one thread |
| start_tid | input | TW | Thread addressed by the command |
| start_load | input | 1 | 1: load new operands; 0: resume saved progress |
| start_intr | input | 1 | Move may be interrupted |
| start_src | input | AW | Source byte address (word aligned) |
| start_dst | input | AW | Destination byte address (word aligned) |
| start_len | input | LW | Length in bytes |
| irq_pending | input | 1 | A hardware interrupt is waiting |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request |
| mem_addr | output | AW | Byte address for the read or write |
| mem_rdata | input | 32 | Read data, valid in the read cycle |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for the write |
| done_valid | output | 1 | Thread handed back |
| done_tid | output | TW | Thread handed back |
| done_pc_inc | output | 4 | Program-counter increment (6 on completion, 0 on yield) |
| done_yield | output | 1 | Hand-back was an early interrupt exit |

## Verification
The assertions assume that memory answers a read in the same cycle as the request, and that the source and destination addresses are word aligned. They also assume that a start command names an idle thread, or else is one the design must drop. The bench's memory model returns data combinationally from the requested address. Every operand address it uses is a multiple of four. Source and destination areas are kept apart, so any stray write shows up as a changed byte outside the expected window.

// File: rtl/bm_pkg.sv
package bm_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_WRITE,
        S_STEP,
        S_RETIRE,
        S_YIELD
    } bm_state_e;

    localparam int unsigned WORD_BYTES  = 4;
    localparam logic [3:0]  PC_INC_MOVE = 4'd6;
endpackage

// File: rtl/bm_thread_file.sv
module bm_thread_file #(
    parameter int NTHREAD = 4,
    parameter int AW      = 16,
    parameter int LW      = 12,
    parameter int TW      = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               st_valid,
    input  logic [TW-1:0]      st_tid,
    input  logic               st_load,
    input  logic               st_intr,
    input  logic [AW-1:0]      st_src,
    input  logic [AW-1:0]      st_dst,
    input  logic [LW-1:0]      st_len,
    input  logic               up_en,
    input  logic [TW-1:0]      up_tid,
    input  logic [AW-1:0]      up_src,
    input  logic [AW-1:0]      up_dst,
    input  logic [LW-1:0]      up_len,
    input  logic               clr_en,
    input  logic [TW-1:0]      clr_tid,
    input  logic [TW-1:0]      rd_tid,
    output logic [AW-1:0]      rd_src,
    output logic [AW-1:0]      rd_dst,
    output logic [LW-1:0]      rd_len,
    output logic               rd_intr,
    output logic [NTHREAD-1:0] active
);
    logic [AW-1:0] src_q  [NTHREAD];
    logic [AW-1:0] dst_q  [NTHREAD];
    logic [LW-1:0] len_q  [NTHREAD];
    logic          intr_q [NTHREAD];
    logic [NTHREAD-1:0] act_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
            for (int g = 0; g < NTHREAD; g++) begin
                src_q[g]  <= '0;
                dst_q[g]  <= '0;
                len_q[g]  <= '0;
                intr_q[g] <= 1'b0;
            end
        end else begin
            for (int g = 0; g < NTHREAD; g++) begin
                if (st_valid && st_tid == TW'(g) && !act_q[g]) begin
                    act_q[g]  <= 1'b1;
                    intr_q[g] <= st_intr;
                    if (st_load) begin
                        src_q[g] <= st_src;
                        dst_q[g] <= st_dst;
                        len_q[g] <= st_len;
                    end
                end else begin
                    if (up_en && up_tid == TW'(g)) begin
                        src_q[g] <= up_src;
                        dst_q[g] <= up_dst;
                        len_q[g] <= up_len;
                    end
                    if (clr_en && clr_tid == TW'(g)) begin
                        act_q[g] <= 1'b0;
                    end
                end
            end
        end
    end

    assign rd_src  = src_q[rd_tid];
    assign rd_dst  = dst_q[rd_tid];
    assign rd_len  = len_q[rd_tid];
    assign rd_intr = intr_q[rd_tid];
    assign active  = act_q;
endmodule

// File: rtl/bm_rr_pick.sv
module bm_rr_pick #(
    parameter int N  = 4,
    parameter int TW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [TW-1:0] last,
    output logic          any,
    output logic [TW-1:0] grant
);
    always_comb begin
        any   = 1'b0;
        grant = '0;
        // highest offset first, so the nearest requester after last wins
        for (int k = N; k >= 1; k--) begin
            if (req[(int'(last) + k) % N]) begin
                any   = 1'b1;
                grant = TW'((int'(last) + k) % N);
            end
        end
    end
endmodule

// File: rtl/bm_step.sv
module bm_step #(
    parameter int AW = 16,
    parameter int LW = 12
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [LW-1:0] len,
    output logic [AW-1:0] nsrc,
    output logic [AW-1:0] ndst,
    output logic [LW-1:0] nlen,
    output logic [3:0]    be,
    output logic          last
);
    localparam logic [LW-1:0] WB = LW'(bm_pkg::WORD_BYTES);

    assign nsrc = src + AW'(bm_pkg::WORD_BYTES);
    assign ndst = dst + AW'(bm_pkg::WORD_BYTES);
    assign last = (len <= WB);
    assign nlen = last ? '0 : (len - WB);

    always_comb begin
        if (len >= WB) be = 4'b1111;
        else begin
            unique case (len[1:0])
                2'd3:    be = 4'b0111;
                2'd2:    be = 4'b0011;
                2'd1:    be = 4'b0001;
                default: be = 4'b0000;
            endcase
        end
    end
endmodule

// File: rtl/bm_seq.sv
module bm_seq #(
    parameter int NTHREAD = 4,
    parameter int AW      = 16,
    parameter int LW      = 12,
    localparam int TW     = (NTHREAD > 1) ? $clog2(NTHREAD) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_valid,
    input  logic [TW-1:0] start_tid,
    input  logic          start_load,
    input  logic          start_intr,
    input  logic [AW-1:0] start_src,
    input  logic [AW-1:0] start_dst,
    input  logic [LW-1:0] start_len,
    input  logic          irq_pending,
    output logic          mem_rd_en,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_addr,
    input  logic [31:0]   mem_rdata,
    output logic [31:0]   mem_wdata,
    output logic [3:0]    mem_be,
    output logic          done_valid,
    output logic [TW-1:0] done_tid,
    output logic [3:0]    done_pc_inc,
    output logic          done_yield
);
    import bm_pkg::*;

    bm_state_e     state_q, state_d;
    logic [TW-1:0] cur_q, cur_d;
    logic [TW-1:0] last_q, last_d;
    logic [31:0]   data_q;

    logic [NTHREAD-1:0] active;
    logic          pick_any;
    logic [TW-1:0] pick_tid;
    logic [TW-1:0] rd_tid;
    logic [AW-1:0] t_src, t_dst, n_src, n_dst;
    logic [LW-1:0] t_len, n_len;
    logic          t_intr, w_last;
    logic [3:0]    w_be;

    assign rd_tid = (state_q == S_IDLE) ? pick_tid : cur_q;

    bm_thread_file #(.NTHREAD(NTHREAD), .AW(AW), .LW(LW), .TW(TW)) u_tf (
        .clk     (clk),
        .rst_n   (rst_n),
        .st_valid(start_valid),
        .st_tid  (start_tid),
        .st_load (start_load),
        .st_intr (start_intr),
        .st_src  (start_src),
        .st_dst  (start_dst),
        .st_len  (start_len),
        .up_en   (state_q == S_STEP),
        .up_tid  (cur_q),
        .up_src  (n_src),
        .up_dst  (n_dst),
        .up_len  (n_len),
        .clr_en  (done_valid),
        .clr_tid (cur_q),
        .rd_tid  (rd_tid),
        .rd_src  (t_src),
        .rd_dst  (t_dst),
        .rd_len  (t_len),
        .rd_intr (t_intr),
        .active  (active)
    );

    bm_rr_pick #(.N(NTHREAD), .TW(TW)) u_pick (
        .req  (active),
        .last (last_q),
        .any  (pick_any),
        .grant(pick_tid)
    );

    bm_step #(.AW(AW), .LW(LW)) u_step (
        .src (t_src),
        .dst (t_dst),
        .len (t_len),
        .nsrc(n_src),
        .ndst(n_dst),
        .nlen(n_len),
        .be  (w_be),
        .last(w_last)
    );

    // state register and data latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cur_q   <= '0;
            last_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            last_q  <= last_d;
            if (state_q == S_READ) data_q <= mem_rdata;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        last_d  = last_q;
        unique case (state_q)
            S_IDLE: begin
                if (pick_any) begin
                    cur_d   = pick_tid;
                    last_d  = pick_tid;
                    state_d = (t_len == '0) ? S_RETIRE : S_READ;
                end
            end
            S_READ:  state_d = S_WRITE;
            S_WRITE: state_d = S_STEP;
            S_STEP: begin
                if (w_last)                   state_d = S_RETIRE;
                else if (t_intr && irq_pending) state_d = S_YIELD;
                else                          state_d = S_IDLE;
            end
            S_RETIRE: state_d = S_IDLE;
            S_YIELD:  state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_rd_en   = (state_q == S_READ);
        mem_wr_en   = (state_q == S_WRITE);
        mem_addr    = (state_q == S_WRITE) ? t_dst : t_src;
        mem_wdata   = data_q;
        mem_be      = (state_q == S_WRITE) ? w_be : 4'b0000;
        done_valid  = (state_q == S_RETIRE) || (state_q == S_YIELD);
        done_tid    = cur_q;
        done_pc_inc = (state_q == S_RETIRE) ? PC_INC_MOVE : 4'd0;
        done_yield  = (state_q == S_YIELD);
    end
endmodule

// File: rtl/bm_seq_chk.sv
module bm_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_rd_en,
    input logic       mem_wr_en,
    input logic [3:0] mem_be,
    input logic       done_valid,
    input logic [3:0] done_pc_inc,
    input logic       done_yield
);
    p_rw_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    p_rd_then_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> mem_wr_en);

    p_wr_after_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en));

    p_be_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_be == 4'b1111 || mem_be == 4'b0111 ||
                       mem_be == 4'b0011 || mem_be == 4'b0001));

    p_done_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_yield) |-> (done_pc_inc == 4'd6));

    p_yield_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_yield) |-> (done_pc_inc == 4'd0));

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    p_no_mem_at_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !(mem_rd_en || mem_wr_en));
endmodule

bind bm_seq bm_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .mem_be     (mem_be),
    .done_valid (done_valid),
    .done_pc_inc(done_pc_inc),
    .done_yield (done_yield)
);

// File: tb/sim_bm_seq.sv
`timescale 1ns/1ps
module sim_bm_seq;
    localparam int NT = 4;
    localparam int AW = 16;
    localparam int LW = 12;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_valid = 1'b0;
    logic [TW-1:0] start_tid = '0;
    logic          start_load = 1'b0;
    logic          start_intr = 1'b0;
    logic [AW-1:0] start_src = '0;
    logic [AW-1:0] start_dst = '0;
    logic [LW-1:0] start_len = '0;
    logic          irq_pending = 1'b0;
    logic          mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata, mem_wdata;
    logic [3:0]    mem_be;
    logic          done_valid, done_yield;
    logic [TW-1:0] done_tid;
    logic [3:0]    done_pc_inc;

    always #10 clk = ~clk;

    bm_seq #(.NTHREAD(NT), .AW(AW), .LW(LW)) u0 (.*);

    logic [31:0] mem [256];
    assign mem_rdata = mem[mem_addr[9:2]];

    int checks = 0, failures = 0;
    int dn_cnt = 0, rd_cnt = 0, wr_cnt = 0;
    int dn_tid [256];
    int dn_pc  [256];
    int dn_y   [256];

    function automatic logic [31:0] pat(int w);
        return (32'(w) * 32'h01030507) ^ 32'h5A3C96E1;
    endfunction

    function automatic logic [7:0] pat_byte(int a);
        logic [31:0] w = pat((a >> 2) & 255);
        return w[8*(a & 3) +: 8];
    endfunction

    function automatic logic [7:0] mem_byte(int a);
        logic [31:0] w = mem[(a >> 2) & 255];
        return w[8*(a & 3) +: 8];
    endfunction

    always @(negedge clk) begin
        if (mem_wr_en) begin
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end
        if (mem_rd_en) rd_cnt <= rd_cnt + 1;
        if (mem_wr_en) wr_cnt <= wr_cnt + 1;
        if (done_valid) begin
            dn_tid[dn_cnt & 255] <= int'(done_tid);
            dn_pc[dn_cnt & 255]  <= int'(done_pc_inc);
            dn_y[dn_cnt & 255]   <= int'(done_yield);
            dn_cnt <= dn_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic init_mem();
        @(negedge clk); #1;
        for (int i = 0; i < 256; i++) mem[i] = pat(i);
    endtask

    task automatic start(input int tid, input bit load, input bit intr, input int src, input int dst, input int len);
        @(negedge clk);
        start_valid = 1'b1;
        start_tid   = TW'(tid);
        start_load  = load;
        start_intr  = intr;
        start_src   = AW'(src);
        start_dst   = AW'(dst);
        start_len   = LW'(len);
        @(negedge clk);
        start_valid = 1'b0;
    endtask

    task automatic wait_done(input int target);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); #1;
            if (dn_cnt >= target) break;
        end
    endtask

    // copied bytes must match source, the following bytes must be untouched
    task automatic check_copy(input int src, input int dst, input int len, input string req);
        int bad = -1;
        logic [7:0] e, a;
        for (int b = 0; b < len + 8; b++) begin
            e = (b < len) ? pat_byte(src + b) : pat_byte(dst + b);
            a = mem_byte(dst + b);
            if (a !== e && bad < 0) bad = b;
        end
        chk(bad < 0, req, "copy first bad byte", bad, -1);
    endtask

    initial begin
        #(20.0 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int base, rb, wb, words, ny;
        for (int i = 0; i < 256; i++) mem[i] = pat(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: quiet after reset
        chk(!mem_rd_en && !mem_wr_en, "R1", "mem request after reset", int'(mem_rd_en | mem_wr_en), 0);
        chk(!done_valid, "R1", "done after reset", int'(done_valid), 0);
        repeat (5) @(negedge clk); #1;
        chk(dn_cnt == 0 && rd_cnt == 0, "R1", "activity while idle", dn_cnt + rd_cnt, 0);

        // R2 R3 R4 R5: length sweep on one thread at a time
        for (int len = 0; len <= 13; len++) begin
            init_mem();
            base = dn_cnt; rb = rd_cnt; wb = wr_cnt;
            words = (len + 3) / 4;
            start(len % NT, 1'b1, 1'b0, 32'h40 + 16 * len, 32'h240 + 16 * len, len);
            wait_done(base + 1);
            chk(dn_cnt == base + 1, "R4", "done count", dn_cnt - base, 1);
            chk(dn_tid[base] == len % NT, "R4", "done tid", dn_tid[base], len % NT);
            chk(dn_pc[base] == 6 && dn_y[base] == 0, "R4", "pc_inc on completion", dn_pc[base], 6);
            chk(rd_cnt - rb == words, (len == 0) ? "R5" : "R2", "reads", rd_cnt - rb, words);
            chk(wr_cnt - wb == words, (len == 0) ? "R5" : "R2", "writes", wr_cnt - wb, words);
            check_copy(32'h40 + 16 * len, 32'h240 + 16 * len, len, (len % 4 != 0) ? "R3" : "R2");
        end

        // R9: four threads together finish by word count
        init_mem();
        base = dn_cnt; rb = rd_cnt;
        start(0, 1'b1, 1'b0, 32'h000, 32'h200, 16);
        start(1, 1'b1, 1'b0, 32'h040, 32'h240, 4);
        start(2, 1'b1, 1'b0, 32'h080, 32'h280, 12);
        start(3, 1'b1, 1'b0, 32'h0C0, 32'h2C0, 8);
        wait_done(base + 4);
        chk(dn_tid[base] == 1, "R9", "1st done tid", dn_tid[base], 1);
        chk(dn_tid[base+1] == 3, "R9", "2nd done tid", dn_tid[base+1], 3);
        chk(dn_tid[base+2] == 2, "R9", "3rd done tid", dn_tid[base+2], 2);
        chk(dn_tid[base+3] == 0, "R9", "4th done tid", dn_tid[base+3], 0);
        chk(rd_cnt - rb == 10, "R9", "total reads", rd_cnt - rb, 10);
        check_copy(32'h000, 32'h200, 16, "R9");
        check_copy(32'h040, 32'h240, 4, "R9");
        check_copy(32'h080, 32'h280, 12, "R9");
        check_copy(32'h0C0, 32'h2C0, 8, "R9");

        // R6 R7: interruptible move yields each word, resume continues
        init_mem();
        irq_pending = 1'b1;
        base = dn_cnt; rb = rd_cnt;
        start(2, 1'b1, 1'b1, 32'h100, 32'h300, 18);
        wait_done(base + 1);
        chk(dn_y[base] == 1, "R6", "yield flag", dn_y[base], 1);
        chk(dn_pc[base] == 0, "R6", "pc_inc on yield", dn_pc[base], 0);
        chk(rd_cnt - rb == 1, "R6", "words before yield", rd_cnt - rb, 1);
        check_copy(32'h100, 32'h300, 4, "R6");
        ny = 1;
        for (int k = 0; k < 10; k++) begin
            if (dn_y[dn_cnt - 1] == 0) break;
            base = dn_cnt;
            start(2, 1'b0, 1'b1, 0, 0, 0);
            wait_done(base + 1);
            if (dn_y[base] == 1) ny++;
        end
        chk(ny == 4, "R7", "yields in five-word move", ny, 4);
        chk(dn_pc[dn_cnt - 1] == 6, "R7", "final pc_inc", dn_pc[dn_cnt - 1], 6);
        chk(rd_cnt - rb == 5, "R7", "total reads after resumes", rd_cnt - rb, 5);
        check_copy(32'h100, 32'h300, 18, "R7");

        // R8: non-interruptible move ignores the pending interrupt
        init_mem();
        base = dn_cnt;
        start(3, 1'b1, 1'b0, 32'h140, 32'h340, 12);
        wait_done(base + 1);
        repeat (10) @(negedge clk); #1;
        chk(dn_cnt == base + 1, "R8", "hand-backs", dn_cnt - base, 1);
        chk(dn_y[base] == 0 && dn_pc[base] == 6, "R8", "no yield", dn_y[base], 0);
        check_copy(32'h140, 32'h340, 12, "R8");
        irq_pending = 1'b0;

        // R10: start on a busy thread is dropped
        init_mem();
        base = dn_cnt;
        start(0, 1'b1, 1'b0, 32'h000, 32'h200, 32);
        start(0, 1'b1, 1'b0, 32'h080, 32'h380, 4);
        wait_done(base + 1);
        repeat (40) @(negedge clk); #1;
        chk(dn_cnt == base + 1, "R10", "hand-backs", dn_cnt - base, 1);
        check_copy(32'h000, 32'h200, 32, "R10");
        check_copy(32'h080, 32'h380, 0, "R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule